// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Override

This block controls eight general-purpose I/O pins. A direction register and an output latch decide whether each pin drives a value or listens. Incoming pad levels pass through a two-flop synchronizer before software or other logic reads them. A small register bus reads and writes the direction, latch and configuration state, and also reads the synchronized pin levels.

Other functions can take a pin away from the port, and each pin has a fixed priority order. On the low nibble, an enabled external-memory interface drives address bits onto the pins. On the high nibble, a pin can be claimed as an analog input, which disables its driver and makes it read as zero. A high pin can also carry one of four PWM outputs. Pins 4 and 5 belong to PWM unit 2, and pins 6 and 7 belong to PWM unit 1. Each unit can be configured to release its pins to high impedance while it reports a shutdown.

The pad itself is outside this block. The block only produces an output enable and an output value for each pin, and it receives the raw level from the pad.

Top module: `pin_mux_port`

## Requirements
- R1: After reset, the direction register reads 8'hFF, the latch reads 8'h00 and the configuration register reads 8'h0F. With no override active, every pad_oe bit is 0.
- R2: A digital pin with no override active is driven when its direction bit is 0 and released when the bit is 1. A driven pin outputs its latch bit. pad_out is 0 on every pin whose pad_oe is 0.
- R3: A bus write to address 1 or address 2 updates the latch. A read of address 1 returns the stored latch value.
- R4: A read of address 2, and the pin_in output, return the pad levels delayed by two clock edges. Bits for pins in analog mode read 0.
- R5: While mem_en is 1, pins 0 to 3 are driven with mem_addr[0] to mem_addr[3], whatever the direction and latch bits hold.
- R6: Configuration bit k (k = 0..3) set to 1 puts pin 4+k in analog mode. Its pad_oe is then 0, regardless of direction and PWM claims.
- R7: While configuration bit 4 is 0 and pwm_on[k] is 1, pin 4+k is driven with pwm_val[k]. Bits 0 and 1 belong to PWM unit 2, and bits 2 and 3 belong to PWM unit 1.
- R8: While configuration bit 4 is 1, pwm_on and pwm_val have no effect, and the high pins follow the direction and latch bits.
- R9: Configuration bit 5 releases the PWM-driven pins of unit 2 while sd_unit2 is 1. Bit 6 does the same for unit 1 and sd_unit1. A unit's shutdown input has no effect while its release bit is 0.
- R10: Address 0 reads back the direction register. Address 3 reads back the configuration register, with bit 7 always reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 direction, 1 latch, 2 pins, 3 configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| mem_en | input | 1 | External-memory interface owns pins 0 to 3 |
| mem_addr | input | 4 | Address bits driven onto pins 0 to 3 |
| pwm_on | input | 4 | PWM claim for pins 4 to 7 |
| pwm_val | input | 4 | PWM levels for pins 4 to 7 |
| sd_unit1 | input | 1 | Shutdown from PWM unit 1 (pins 6, 7) |
| sd_unit2 | input | 1 | Shutdown from PWM unit 2 (pins 4, 5) |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pin_in | output | 8 | Synchronized pin levels, analog pins masked |

## Verification
Every pin output is a combinational function of the registered state and the override inputs. A corrupted direction, latch or configuration bit therefore shows on pad_oe or pad_out in the same cycle the bad state is stored, and on bus_rdata as soon as that register is addressed. A synchronizer fault shows as a pin read one edge early or one edge late. The bench checks the read both one edge and two edges after a pad change, so either error appears. Priority faults only appear when overrides compete, so the bench stacks analog mode, PWM claims, shutdowns and memory ownership against the port settings.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
    parameter int unsigned NPIN = 8;
    parameter int unsigned NLO  = 4;
    localparam int unsigned NHI = NPIN - NLO;
    parameter int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RA_DIR = 2'd0,
        RA_LAT = 2'd1,
        RA_PIN = 2'd2,
        RA_CFG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] lat;
        logic [NHI-1:0]  ana;
        logic            altmap;
        logic            ts2;
        logic            ts1;
    } regs_t;

    localparam regs_t REGS_RST = '{
        dir:    {NPIN{1'b1}},
        lat:    {NPIN{1'b0}},
        ana:    {NHI{1'b1}},
        altmap: 1'b0,
        ts2:    1'b0,
        ts1:    1'b0
    };
endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
    import pmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] pin_vis,
    output logic [NPIN-1:0] rdata,
    output regs_t           regs_o
);
    regs_t regs_d, regs_q;
    logic [NPIN-1:0] cfg_rd;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (reg_addr_e'(addr))
                RA_DIR: regs_d.dir = wdata;
                RA_LAT, RA_PIN: regs_d.lat = wdata;
                RA_CFG: begin
                    regs_d.ana    = wdata[NHI-1:0];
                    regs_d.altmap = wdata[NHI];
                    regs_d.ts2    = wdata[NHI+1];
                    regs_d.ts1    = wdata[NHI+2];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rd = '0;
        cfg_rd[NHI-1:0] = regs_q.ana;
        cfg_rd[NHI]     = regs_q.altmap;
        cfg_rd[NHI+1]   = regs_q.ts2;
        cfg_rd[NHI+2]   = regs_q.ts1;
        unique case (reg_addr_e'(addr))
            RA_DIR:  rdata = regs_q.dir;
            RA_LAT:  rdata = regs_q.lat;
            RA_PIN:  rdata = pin_vis;
            RA_CFG:  rdata = cfg_rd;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/pmp_sync.sv
module pmp_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_in;
        for (int s = 1; s < STAGES; s++) sh_d[s] = sh_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/pmp_pinmux.sv
module pmp_pinmux
    import pmp_pkg::*;
(
    input  regs_t           regs_i,
    input  logic            mem_en,
    input  logic [NLO-1:0]  mem_addr,
    input  logic [NHI-1:0]  pwm_on,
    input  logic [NHI-1:0]  pwm_val,
    input  logic            sd_unit1,
    input  logic            sd_unit2,
    output logic [NPIN-1:0] oe_o,
    output logic [NPIN-1:0] out_o
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic oe_b, val_b;
        if (i < NLO) begin : g_lo
            always_comb begin
                if (mem_en) begin
                    oe_b  = 1'b1;
                    val_b = mem_addr[i];
                end else begin
                    oe_b  = ~regs_i.dir[i];
                    val_b = regs_i.lat[i];
                end
            end
        end else begin : g_hi
            localparam int unsigned K  = i - NLO;
            localparam bit          U1 = (K >= NHI / 2);
            logic sd_b, ts_b;
            assign sd_b = U1 ? sd_unit1 : sd_unit2;
            assign ts_b = U1 ? regs_i.ts1 : regs_i.ts2;
            always_comb begin
                if (regs_i.ana[K]) begin
                    oe_b  = 1'b0;
                    val_b = 1'b0;
                end else if (pwm_on[K] && !regs_i.altmap) begin
                    oe_b  = !(sd_b && ts_b);
                    val_b = pwm_val[K];
                end else begin
                    oe_b  = ~regs_i.dir[i];
                    val_b = regs_i.lat[i];
                end
            end
        end
        assign oe_o[i]  = oe_b;
        assign out_o[i] = oe_b & val_b;
    end
endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port
    import pmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [1:0]      bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic            mem_en,
    input  logic [NLO-1:0]  mem_addr,
    input  logic [NHI-1:0]  pwm_on,
    input  logic [NHI-1:0]  pwm_val,
    input  logic            sd_unit1,
    input  logic            sd_unit2,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pin_in
);
    regs_t           regs_q;
    logic [NPIN-1:0] sync_q;
    logic [NPIN-1:0] ana_mask;

    pmp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .q_out (sync_q)
    );

    assign ana_mask = {regs_q.ana, {NLO{1'b0}}};
    assign pin_in   = sync_q & ~ana_mask;

    pmp_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_vis (pin_in),
        .rdata   (bus_rdata),
        .regs_o  (regs_q)
    );

    pmp_pinmux u_mux (
        .regs_i   (regs_q),
        .mem_en   (mem_en),
        .mem_addr (mem_addr),
        .pwm_on   (pwm_on),
        .pwm_val  (pwm_val),
        .sd_unit1 (sd_unit1),
        .sd_unit2 (sd_unit2),
        .oe_o     (pad_oe),
        .out_o    (pad_out)
    );
endmodule

module pmp_chk
    import pmp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [1:0]      bus_addr,
    input logic [NPIN-1:0] bus_wdata,
    input logic [NPIN-1:0] bus_rdata,
    input logic            mem_en,
    input logic [NLO-1:0]  mem_addr,
    input logic [NHI-1:0]  pwm_on,
    input logic            sd_unit2,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_out,
    input regs_t           regs_q
);
    a_r1_reset_state: assert property (@(posedge clk) $rose(rst_n) |->
        (regs_q.dir == {NPIN{1'b1}} && regs_q.lat == '0 && regs_q.ana == {NHI{1'b1}}));

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> regs_q.lat == $past(bus_wdata));

    a_r4_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> (bus_rdata[NPIN-1:NLO] & regs_q.ana) == '0);

    a_r5_mem_owns_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (pad_oe[NLO-1:0] == {NLO{1'b1}} && pad_out[NLO-1:0] == mem_addr));

    a_r6_analog_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[NPIN-1:NLO] & regs_q.ana) == '0);

    a_r9_unit2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_unit2 && regs_q.ts2 && !regs_q.altmap && pwm_on[0]) |-> !pad_oe[NLO]);
endmodule

bind pin_mux_port pmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .pwm_on    (pwm_on),
    .sd_unit2  (sd_unit2),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .regs_q    (regs_q)
);

// File: tb/sim_pin_mux_port.sv
`timescale 1ns/1ps
module sim_pin_mux_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mem_en = 1'b0;
    logic [3:0] mem_addr = 4'h0;
    logic [3:0] pwm_on = 4'h0;
    logic [3:0] pwm_val = 4'h0;
    logic       sd_unit1 = 1'b0;
    logic       sd_unit2 = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pin_in;

    always #2.5 clk = ~clk;

    pin_mux_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_en(mem_en),
        .mem_addr(mem_addr), .pwm_on(pwm_on), .pwm_val(pwm_val),
        .sd_unit1(sd_unit1), .sd_unit2(sd_unit2), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pin_in(pin_in)
    );

    typedef struct {
        int       kind;
        logic [7:0] exp;
        string    req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic push(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        push(2, exp, req);
    endtask

    task automatic obs(input logic [7:0] oe, input logic [7:0] out, input string req);
        @(negedge clk);
        push(0, oe, req);
        push(1, out, req);
    endtask

    task automatic ovr(input logic me, input logic [3:0] ma, input logic [3:0] on,
                       input logic [3:0] val, input logic s1, input logic s2);
        @(negedge clk);
        mem_en = me; mem_addr = ma; pwm_on = on; pwm_val = val;
        sd_unit1 = s1; sd_unit2 = s2;
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = pad_oe;
                    1: act = pad_out;
                    2: act = bus_rdata;
                    default: act = pin_in;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R10 readback
        obs(8'h00, 8'h00, "R1");
        rd(2'd0, 8'hFF, "R1");
        rd(2'd1, 8'h00, "R1");
        rd(2'd3, 8'h0F, "R10");
        // R2 + R6: outputs, high nibble still analog
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA5);
        obs(8'h0F, 8'h05, "R6");
        wr(2'd3, 8'h00);
        obs(8'hFF, 8'hA5, "R2");
        // R3 latch via both addresses
        rd(2'd1, 8'hA5, "R3");
        wr(2'd2, 8'h3C);
        obs(8'hFF, 8'h3C, "R3");
        rd(2'd1, 8'h3C, "R3");
        wr(2'd0, 8'hFF);
        obs(8'h00, 8'h00, "R2");
        // R4 synchronizer depth
        @(negedge clk);
        pad_in = 8'hC3;
        rd(2'd2, 8'h00, "R4");
        rd(2'd2, 8'hC3, "R4");
        @(negedge clk); push(3, 8'hC3, "R4");
        wr(2'd3, 8'h05);
        rd(2'd2, 8'h83, "R4");
        @(negedge clk); push(3, 8'h83, "R4");
        wr(2'd0, 8'h00);
        obs(8'hAF, 8'h2C, "R6");
        // R5 memory ownership
        wr(2'd3, 8'h00);
        ovr(1'b1, 4'h9, 4'h0, 4'h0, 1'b0, 1'b0);
        obs(8'hFF, 8'h39, "R5");
        wr(2'd0, 8'hFF);
        obs(8'h0F, 8'h09, "R5");
        // R7 PWM routing
        ovr(1'b0, 4'h0, 4'hF, 4'h5, 1'b0, 1'b0);
        obs(8'hF0, 8'h50, "R7");
        ovr(1'b0, 4'h0, 4'h2, 4'h2, 1'b0, 1'b0);
        obs(8'h20, 8'h20, "R7");
        // R8 alternate mapping ignores PWM
        wr(2'd3, 8'h10);
        ovr(1'b0, 4'h0, 4'hF, 4'hF, 1'b0, 1'b0);
        obs(8'h00, 8'h00, "R8");
        wr(2'd0, 8'h00);
        obs(8'hFF, 8'h3C, "R8");
        // R9 shutdown release
        wr(2'd0, 8'hFF);
        wr(2'd3, 8'h20);
        ovr(1'b0, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1);
        obs(8'hC0, 8'hC0, "R9");
        ovr(1'b0, 4'h0, 4'hF, 4'hF, 1'b1, 1'b1);
        obs(8'hC0, 8'hC0, "R9");
        wr(2'd3, 8'h60);
        obs(8'h00, 8'h00, "R9");
        ovr(1'b0, 4'h0, 4'hF, 4'hF, 1'b0, 1'b0);
        obs(8'hF0, 8'hF0, "R9");
        // R6 analog beats PWM
        wr(2'd3, 8'h0F);
        obs(8'h00, 8'h00, "R6");
        // R10 configuration readback
        rd(2'd3, 8'h0F, "R10");
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h7F, "R10");
        rd(2'd0, 8'hFF, "R10");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule